// File: doc/BRIEF.md
# Register Rename Alias Table

This block is the rename stage at the front of an out-of-order core. Each cycle it may take one decoded micro-operation. The micro-operation carries a valid flag, a slow flag, a two-bit cluster id, a 7-bit logical destination, two 7-bit logical sources, and three side-effect flags: cexc, icc and useY. The stage turns both sources into physical tags by reading the alias table. If the operation needs a destination, the stage takes the lowest free physical index from a free list and forms the new tag by placing the cluster id above that index. It then records the new tag in the table. One cycle later the renamed operation appears at the scheduler-facing outputs.

The logical space has three parts. Numbers 1 to 31 are integer registers, 32 to 63 are floating-point registers and 64 to 74 are special registers. Number 0 is the zero register. The side-effect flags point the special entries for the floating-point exception state (64), the Y register (69) and the integer condition codes (71) at the same new tag as the destination.

Recovery is coarse. Reset or flush puts every logical register back on its home tag and refills the free list. There is no per-entry release, so once the free indices run out the stage stalls until the next flush.

Top module: `rename_stage`

## Requirements
- R1: After reset, each logical register n (0 to 74) maps to tag n with cluster 0. All outputs are 0, stall is low, and indices 75 to 127 are free.
- R2: Both source lookups return the mapping held before the current operation's own update, so a source equal to the destination returns the older tag.
- R3: A source lookup of logical 0, or of any number above 74, returns tag 0. Such numbers are never remapped.
- R4: A new destination takes the lowest free physical index (0 to 127). Its 9-bit tag is cluster*128 + index, so the cluster sits in bits 8:7.
- R5: When cexc is set on an accepted operation, logical 64 is remapped to that operation's new tag.
- R6: When icc is set on an accepted operation, logical 71 is remapped to that operation's new tag.
- R7: When useY is set on an accepted operation, logical 69 is remapped to that operation's new tag.
- R8: An accepted operation appears one cycle later with out_valid high and with its slow flag and cluster id unchanged. A cycle with no accepted operation drives all outputs to 0 and changes no mapping.
- R9: Stall is high exactly when no free index remains. A valid operation offered during a stall is dropped: out_valid stays low and nothing changes.
- R10: An index is consumed only when an accepted operation has a destination in 1 to 74 or has any side-effect flag set. Otherwise out_pdest is 0 and the free list is untouched.
- R11: Flush has priority over a valid input. On the next cycle the outputs are 0, every mapping is back at its home tag, and allocation restarts at index 75.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous restore of table and free list |
| in_valid | input | 1 | Incoming micro-operation is present |
| in_slow | input | 1 | Long-latency marker, passed through |
| in_cluster | input | 2 | Target execution cluster |
| in_ldest | input | 7 | Logical destination |
| in_lsrc1 | input | 7 | Logical source 1 |
| in_lsrc2 | input | 7 | Logical source 2 |
| in_cexc | input | 1 | Also alias FP exception register (64) |
| in_icc | input | 1 | Also alias condition codes (71) |
| in_usey | input | 1 | Also alias Y register (69) |
| stall | output | 1 | Free list empty; input is not taken |
| out_valid | output | 1 | Renamed operation present |
| out_slow | output | 1 | Passed-through slow flag |
| out_cluster | output | 2 | Passed-through cluster id |
| out_psrc1 | output | 9 | Physical tag of source 1 |
| out_psrc2 | output | 9 | Physical tag of source 2 |
| out_pdest | output | 9 | New physical destination tag, or 0 |

## Verification
The bound checker watches, on every cycle, the properties that need one cycle of history. These are: dropping an input while stalled, the effect of flush, the zero-register lookup, pass-through of slow and cluster, the zero destination when nothing is allocated, and the cluster field of the new tag. Other behaviours only show across several operations, so only the bench scenarios can reveal them. These include the special registers picking up a tag (seen when a later operation reads them), the lowest-free allocation order, draining the free list into a stall, and the restored identity map after flush. The bench reference model predicts each of these independently.

// File: rtl/rename_pkg.sv
package rename_pkg;

    parameter int LREG_W    = 7;
    parameter int NUM_LREG  = 75;
    parameter int PIDX_W    = 7;
    parameter int NUM_PREG  = 1 << PIDX_W;
    parameter int CLUSTER_W = 2;
    parameter int TAG_W     = CLUSTER_W + PIDX_W;

    parameter int LREG_FPEXC = 64;
    parameter int LREG_YREG  = 69;
    parameter int LREG_CC    = 71;

    typedef logic [LREG_W-1:0]    lreg_t;
    typedef logic [PIDX_W-1:0]    pidx_t;
    typedef logic [CLUSTER_W-1:0] cluster_t;
    typedef logic [TAG_W-1:0]     ptag_t;

    typedef struct packed {
        logic     valid;
        logic     slow;
        cluster_t cluster;
        lreg_t    ldest;
        lreg_t    lsrc1;
        lreg_t    lsrc2;
        logic     fpexc;
        logic     cc;
        logic     yreg;
    } uop_t;

    typedef struct packed {
        logic     valid;
        logic     slow;
        cluster_t cluster;
        ptag_t    psrc1;
        ptag_t    psrc2;
        ptag_t    pdest;
    } renamed_t;

    function automatic ptag_t make_tag(cluster_t c, pidx_t i);
        return {c, i};
    endfunction

    function automatic logic is_mapped_lreg(lreg_t r);
        return (r != '0) && (int'(r) < NUM_LREG);
    endfunction

    function automatic logic needs_dest(uop_t u);
        return is_mapped_lreg(u.ldest) || u.fpexc || u.cc || u.yreg;
    endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table
    import rename_pkg::*;
#(
    parameter int N = NUM_LREG
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  lreg_t rd_a1,
    input  lreg_t rd_a2,
    output ptag_t rd_t1,
    output ptag_t rd_t2,
    input  logic  wr_en,
    input  lreg_t wr_addr,
    input  ptag_t wr_tag,
    input  logic  wr_fpexc,
    input  logic  wr_cc,
    input  logic  wr_yreg
);

    ptag_t map_q [N];

    for (genvar e = 0; e < N; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (
                        ((e != 0) && (wr_addr == LREG_W'(e))) ||
                        (wr_fpexc && (e == LREG_FPEXC)) ||
                        (wr_cc    && (e == LREG_CC))    ||
                        (wr_yreg  && (e == LREG_YREG)));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                map_q[e] <= make_tag('0, PIDX_W'(e));
            end else if (hit) begin
                map_q[e] <= wr_tag;
            end
        end
    end

    always_comb begin
        rd_t1 = '0;
        rd_t2 = '0;
        for (int e = 1; e < N; e++) begin
            if (rd_a1 == LREG_W'(e)) rd_t1 = map_q[e];
            if (rd_a2 == LREG_W'(e)) rd_t2 = map_q[e];
        end
    end

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
    import rename_pkg::*;
#(
    parameter int N        = NUM_PREG,
    parameter int RESERVED = NUM_LREG
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  pop,
    output logic  empty,
    output pidx_t idx
);

    function automatic logic [N-1:0] home_mask();
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = (i >= RESERVED);
        return m;
    endfunction

    localparam logic [N-1:0] INIT_MASK = home_mask();

    logic [N-1:0] free_q;

    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && free_q[i]) begin
                idx   = pidx_t'(i);
                found = 1'b1;
            end
        end
    end

    assign empty = ~|free_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            free_q <= INIT_MASK;
        end else if (pop && !empty) begin
            free_q[idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/rename_stage.sv
module rename_stage
    import rename_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 in_valid,
    input  logic                 in_slow,
    input  logic [CLUSTER_W-1:0] in_cluster,
    input  logic [LREG_W-1:0]    in_ldest,
    input  logic [LREG_W-1:0]    in_lsrc1,
    input  logic [LREG_W-1:0]    in_lsrc2,
    input  logic                 in_cexc,
    input  logic                 in_icc,
    input  logic                 in_usey,
    output logic                 stall,
    output logic                 out_valid,
    output logic                 out_slow,
    output logic [CLUSTER_W-1:0] out_cluster,
    output logic [TAG_W-1:0]     out_psrc1,
    output logic [TAG_W-1:0]     out_psrc2,
    output logic [TAG_W-1:0]     out_pdest
);

    uop_t     uop;
    renamed_t out_q;
    logic     accept;
    logic     alloc;
    logic     fl_empty;
    pidx_t    fl_idx;
    ptag_t    new_tag;
    ptag_t    src1_tag;
    ptag_t    src2_tag;

    assign uop = '{valid:   in_valid,
                   slow:    in_slow,
                   cluster: in_cluster,
                   ldest:   in_ldest,
                   lsrc1:   in_lsrc1,
                   lsrc2:   in_lsrc2,
                   fpexc:   in_cexc,
                   cc:      in_icc,
                   yreg:    in_usey};

    assign stall   = fl_empty;
    assign accept  = uop.valid && !fl_empty && !flush;
    assign alloc   = accept && needs_dest(uop);
    assign new_tag = make_tag(uop.cluster, fl_idx);

    rename_free_list #(
        .N        (NUM_PREG),
        .RESERVED (NUM_LREG)
    ) u_free (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .pop   (alloc),
        .empty (fl_empty),
        .idx   (fl_idx)
    );

    rename_map_table #(
        .N (NUM_LREG)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_a1    (uop.lsrc1),
        .rd_a2    (uop.lsrc2),
        .rd_t1    (src1_tag),
        .rd_t2    (src2_tag),
        .wr_en    (alloc),
        .wr_addr  (uop.ldest),
        .wr_tag   (new_tag),
        .wr_fpexc (uop.fpexc),
        .wr_cc    (uop.cc),
        .wr_yreg  (uop.yreg)
    );

    always_ff @(posedge clk) begin
        if (rst || flush || !accept) begin
            out_q <= '0;
        end else begin
            out_q.valid   <= 1'b1;
            out_q.slow    <= uop.slow;
            out_q.cluster <= uop.cluster;
            out_q.psrc1   <= src1_tag;
            out_q.psrc2   <= src2_tag;
            out_q.pdest   <= alloc ? new_tag : '0;
        end
    end

    assign out_valid   = out_q.valid;
    assign out_slow    = out_q.slow;
    assign out_cluster = out_q.cluster;
    assign out_psrc1   = out_q.psrc1;
    assign out_psrc2   = out_q.psrc2;
    assign out_pdest   = out_q.pdest;

endmodule

// File: rtl/rename_checker.sv
module rename_checker
    import rename_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 flush,
    input logic                 in_valid,
    input logic                 in_slow,
    input logic [CLUSTER_W-1:0] in_cluster,
    input logic [LREG_W-1:0]    in_ldest,
    input logic [LREG_W-1:0]    in_lsrc1,
    input logic                 in_cexc,
    input logic                 in_icc,
    input logic                 in_usey,
    input logic                 stall,
    input logic                 out_valid,
    input logic                 out_slow,
    input logic [CLUSTER_W-1:0] out_cluster,
    input logic [TAG_W-1:0]     out_psrc1,
    input logic [TAG_W-1:0]     out_pdest
);

    logic taken;
    assign taken = in_valid && !stall && !flush;

    // R9: a stalled input never reaches the output
    a_r9_stall_drops: assert property (@(posedge clk) disable iff (rst)
        (stall && in_valid) |=> !out_valid);

    // R11: flush empties the output register
    a_r11_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid && out_pdest == '0));

    // R3: the zero register always reads as tag 0
    a_r3_zero_source: assert property (@(posedge clk) disable iff (rst)
        (taken && in_lsrc1 == '0) |=> (out_psrc1 == '0));

    // R8: slow and cluster pass through with one cycle of latency
    a_r8_pass_through: assert property (@(posedge clk) disable iff (rst)
        taken |=> (out_valid && out_slow == $past(in_slow)
                   && out_cluster == $past(in_cluster)));

    // R10: nothing allocated when there is no destination and no flag
    a_r10_no_dest: assert property (@(posedge clk) disable iff (rst)
        (taken && in_ldest == '0 && !in_cexc && !in_icc && !in_usey)
        |=> (out_pdest == '0));

    // R4: an allocated tag carries the cluster in its upper bits
    a_r4_cluster_field: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_pdest != '0)
        |-> (out_pdest[TAG_W-1 -: CLUSTER_W] == out_cluster));

endmodule

bind rename_stage rename_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_slow     (in_slow),
    .in_cluster  (in_cluster),
    .in_ldest    (in_ldest),
    .in_lsrc1    (in_lsrc1),
    .in_cexc     (in_cexc),
    .in_icc      (in_icc),
    .in_usey     (in_usey),
    .stall       (stall),
    .out_valid   (out_valid),
    .out_slow    (out_slow),
    .out_cluster (out_cluster),
    .out_psrc1   (out_psrc1),
    .out_pdest   (out_pdest)
);

// File: tb/tb_rename_stage.sv
`timescale 1ns/1ps
module tb_rename_stage;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_slow = 1'b0;
    logic [1:0] in_cluster = '0;
    logic [6:0] in_ldest = '0;
    logic [6:0] in_lsrc1 = '0;
    logic [6:0] in_lsrc2 = '0;
    logic       in_cexc = 1'b0;
    logic       in_icc = 1'b0;
    logic       in_usey = 1'b0;
    logic       stall;
    logic       out_valid;
    logic       out_slow;
    logic [1:0] out_cluster;
    logic [8:0] out_psrc1;
    logic [8:0] out_psrc2;
    logic [8:0] out_pdest;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int map_m [75];
    bit free_m [128];
    int e_valid, e_slow, e_cl, e_s1, e_s2, e_pd;

    always #4 clk = ~clk;

    rename_stage dut (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_slow(in_slow), .in_cluster(in_cluster),
        .in_ldest(in_ldest), .in_lsrc1(in_lsrc1), .in_lsrc2(in_lsrc2),
        .in_cexc(in_cexc), .in_icc(in_icc), .in_usey(in_usey),
        .stall(stall), .out_valid(out_valid), .out_slow(out_slow),
        .out_cluster(out_cluster), .out_psrc1(out_psrc1),
        .out_psrc2(out_psrc2), .out_pdest(out_pdest)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_home();
        for (int i = 0; i < 75; i++) map_m[i] = i;
        for (int i = 0; i < 128; i++) free_m[i] = (i >= 75);
    endtask

    function automatic int look(int a);
        if (a <= 0 || a >= 75) return 0;
        return map_m[a];
    endfunction

    function automatic int free_count();
        int n = 0;
        for (int i = 0; i < 128; i++) if (free_m[i]) n++;
        return n;
    endfunction

    task automatic step(bit v, bit sl, int cl, int ld, int s1, int s2,
                        bit cx, bit ic, bit uy, bit fl);
        bit empty, acc, need;
        int idx, tag;
        @(negedge clk);
        in_valid = v; in_slow = sl; in_cluster = 2'(cl);
        in_ldest = 7'(ld); in_lsrc1 = 7'(s1); in_lsrc2 = 7'(s2);
        in_cexc = cx; in_icc = ic; in_usey = uy; flush = fl;
        #1;
        empty = (free_count() == 0);
        check("R9 stall", int'(stall), int'(empty));
        acc  = v && !empty && !fl;
        need = (ld >= 1 && ld < 75) || cx || ic || uy;
        e_valid = 0; e_slow = 0; e_cl = 0; e_s1 = 0; e_s2 = 0; e_pd = 0;
        if (fl) begin
            model_home();
        end else if (acc) begin
            e_valid = 1; e_slow = sl; e_cl = cl;
            e_s1 = look(s1); e_s2 = look(s2);
            if (need) begin
                idx = -1;
                for (int i = 0; i < 128; i++) if (idx < 0 && free_m[i]) idx = i;
                free_m[idx] = 0;
                tag = cl * 128 + idx;
                e_pd = tag;
                if (ld >= 1 && ld < 75) map_m[ld] = tag;
                if (cx) map_m[64] = tag;
                if (ic) map_m[71] = tag;
                if (uy) map_m[69] = tag;
            end
        end
        @(posedge clk);
        #2;
        check("R8 valid", int'(out_valid), e_valid);
        check("R8 slow", int'(out_slow), e_slow);
        check("R8 cluster", int'(out_cluster), e_cl);
        check("R2 psrc1", int'(out_psrc1), e_s1);
        check("R2 psrc2", int'(out_psrc2), e_s2);
        check("R4 pdest", int'(out_pdest), e_pd);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        model_home();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_pdest", int'(out_pdest), 0);
        check("R1 stall", int'(stall), 0);
        // R1: home mapping read back
        step(1, 0, 0, 0, 40, 74, 0, 0, 0, 0);
        check("R1 home src 40", int'(out_psrc1), 40);
        check("R1 home src 74", int'(out_psrc2), 74);

        // R4 + R5: first allocation, cluster 2, index 75 -> 331
        step(1, 1, 2, 5, 5, 0, 1, 0, 0, 0);
        check("R4 first tag", int'(out_pdest), 331);
        check("R2 own dest reads old", int'(out_psrc1), 5);
        step(1, 0, 1, 0, 64, 5, 0, 0, 0, 0);
        check("R5 fpexc alias", int'(out_psrc1), 331);
        check("R5 dest mapped", int'(out_psrc2), 331);
        check("R10 no dest", int'(out_pdest), 0);

        // R6 + R7: icc and useY on separate ops
        step(1, 0, 3, 33, 0, 0, 0, 1, 0, 0);
        check("R6 tag", int'(out_pdest), 3 * 128 + 76);
        step(1, 0, 1, 0, 0, 0, 0, 0, 1, 0);
        check("R7 flag-only alloc", int'(out_pdest), 128 + 77);
        step(1, 0, 0, 0, 71, 69, 0, 0, 0, 0);
        check("R6 cc alias", int'(out_psrc1), 3 * 128 + 76);
        check("R7 y alias", int'(out_psrc2), 128 + 77);

        // R3: zero and out-of-range never remapped
        step(1, 0, 2, 0, 0, 100, 0, 0, 0, 0);
        step(1, 0, 2, 100, 0, 0, 0, 0, 0, 0);
        check("R3 out-of-range dest", int'(out_pdest), 0);
        step(1, 0, 0, 0, 0, 100, 0, 0, 0, 0);
        check("R3 zero src", int'(out_psrc1), 0);
        check("R3 big src", int'(out_psrc2), 0);

        // R8: invalid input changes nothing; next alloc still index 78
        step(0, 1, 3, 10, 1, 2, 1, 1, 1, 0);
        check("R8 invalid ignored", int'(out_valid), 0);
        step(1, 0, 0, 10, 64, 10, 0, 0, 0, 0);
        check("R10 index untouched", int'(out_pdest), 78);
        check("R8 invalid no alias", int'(out_psrc1), 331);
        check("R8 invalid no remap", int'(out_psrc2), 10);

        // R9: drain the free list (49 indices remain)
        for (int k = 0; k < 49; k++) step(1, k[0], k % 4, 1 + (k % 60), 1, 2, 0, 0, 0, 0);
        check("R9 stall raised", int'(stall), 1);
        step(1, 0, 1, 7, 7, 0, 0, 0, 0, 0);
        check("R9 dropped", int'(out_valid), 0);

        // R11: flush beats a valid input and restores home state
        step(1, 0, 1, 9, 9, 0, 0, 0, 0, 1);
        check("R11 flush out", int'(out_valid), 0);
        check("R11 stall cleared", int'(stall), 0);
        step(1, 0, 2, 9, 1, 64, 0, 0, 0, 0);
        check("R11 home src", int'(out_psrc1), 1);
        check("R11 home special", int'(out_psrc2), 64);
        check("R11 restart index", int'(out_pdest), 2 * 128 + 75);
        idle();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule